// File: doc/BRIEF.md
# Low-Power Pad Configuration Hold Controller

This block sits between a general-purpose I/O port and its pads. For every pin the port supplies three settings: output enable, output value and pull enable. In normal operation the block passes them straight to the pads in the same cycle. A single control bit selects whether the pad settings are frozen when the chip drops into a deep low-power mode. If the bit is set, the settings are frozen at that moment and stay frozen through wake-ups, warm resets and any later mode changes. Only a software write of zero or a power-on reset releases them. This lets firmware reprogram the port after waking before the pins ever see the port's reset values.

Deep entry with the bit clear parks the pads at the port's reset state: input, no drive, no pull. The battery-backup mode also parks the pads and ignores the bit. A parked pad returns to live pass-through on the next wake event or warm reset. Shallow modes never freeze anything. A power-on reset clears the bit and forces every pad to input with high impedance. A small register port reads and writes the control bit.

Top module: `pad_hold_ctrl`

## Requirements
- R1: While power-on reset is asserted, and through the two-cycle synchronizer release, every pad reads oe=0, out=0, pull=0. Once reset is released, the control bit reads 0 and the pads pass the port values through.
- R2: The control bit is bit 2 of the register at offset 0x00. It is written by reg_wr and read combinationally on reg_rdata. All other bits at offset 0x00 read 0. Any other offset reads 0, and writes to it change nothing.
- R3: sys_rst and wake never change the control bit. Only a write to offset 0x00 or a power-on reset changes it.
- R4: In the live state, pad_* equals port_* in the same cycle. While sys_rst is high in the live state, pad_* shows the reset configuration (all zero).
- R5: With the bit at 1, when pwr_mode enters hibernate (3) or backup (4) from a non-deep mode, the pads take the port values sampled on that clock edge. From the next cycle on, port changes do not reach the pads.
- R6: A frozen pad configuration persists through sys_rst, wake, and a return of pwr_mode to active (0), idle (1), standby (2) or off (5).
- R7: Writing 0 to the bit while frozen makes the pads follow the port again from the cycle after the write.
- R8: With the bit at 0, entering hibernate (3) or backup (4) parks the pads at all zero. The pads stay parked until a wake or sys_rst pulse, and are live from the following cycle.
- R9: Entering battery-backup (6) parks the pads whatever the bit value. It also drops an existing freeze into the parked state. The bit keeps its value.
- R10: Modes active (0), idle (1), standby (2), off (5) and the unused code 7 never freeze the pads, even with the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sys_rst | input | 1 | Warm (non-power-on) reset indication, active high |
| wake | input | 1 | Wake event pulse from the power sequencer |
| pwr_mode | input | 3 | Current power mode code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| port_oe | input | PINS | Output enable per pin from the port |
| port_out | input | PINS | Output value per pin from the port |
| port_pull | input | PINS | Pull enable per pin from the port |
| pad_oe | output | PINS | Output enable driven to the pads |
| pad_out | output | PINS | Output value driven to the pads |
| pad_pull | output | PINS | Pull enable driven to the pads |

## Verification
The hold state is never visible as a register. A wrong state therefore appears only as a gap between pad_* and port_*, or as pads that are not zero while parked. Either shows in the first cycle after the bad transition, provided the port is moving. The bench changes the port values every cycle so that a freeze or release landing one cycle early or late shows up at once. A corrupted control bit appears immediately on reg_rdata at offset 0x00. It also appears at the next deep entry, as a freeze where a park was expected or the other way round.

// File: rtl/pad_hold_pkg.sv
package pad_hold_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE    = 3'd0,
    PM_IDLE      = 3'd1,
    PM_STANDBY   = 3'd2,
    PM_HIBERNATE = 3'd3,
    PM_BACKUP    = 3'd4,
    PM_OFF       = 3'd5,
    PM_BATTERY   = 3'd6
  } pwr_mode_e;

  typedef enum logic [1:0] {
    HS_LIVE = 2'd0,
    HS_HOLD = 2'd1,
    HS_PARK = 2'd2
  } hold_st_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pull;
  } pad_cfg_t;

  // modes in which the port logic loses power
  function automatic logic is_deep(input logic [2:0] m);
    return (m == PM_HIBERNATE) || (m == PM_BACKUP) || (m == PM_BATTERY);
  endfunction

  // modes in which the control bit may freeze the pads
  function automatic logic is_freezable(input logic [2:0] m);
    return (m == PM_HIBERNATE) || (m == PM_BACKUP);
  endfunction

endpackage

// File: rtl/pad_hold_regs.sv
module pad_hold_regs #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int RET_BIT  = 2,
  parameter int CTRL_OFS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ret_bit,
  output logic          clr_pulse
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(CTRL_OFS);

  logic hit;
  logic bit_en;
  logic bit_d;
  logic bit_q;

  assign hit    = (addr == CTRL_ADDR);
  assign bit_en = wr_en && hit;
  assign bit_d  = wdata[RET_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[RET_BIT] = bit_q;
    end
  end

  assign ret_bit   = bit_q;
  assign clr_pulse = bit_en && !bit_d;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

endmodule

// File: rtl/pad_hold_seq.sv
module pad_hold_seq
  import pad_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       ret_bit,
  input  logic       clr_pulse,
  input  logic       wake,
  input  logic       sys_rst,
  output hold_st_e   state,
  output logic       cap_en
);

  logic [2:0] mode_q;
  hold_st_e   st_q;
  hold_st_e   st_d;
  logic       deep_entry;
  logic       batt_entry;
  logic       exit_ev;

  assign deep_entry = is_deep(mode) && !is_deep(mode_q);
  assign batt_entry = (mode == PM_BATTERY) && (mode_q != PM_BATTERY);
  assign exit_ev    = wake || sys_rst;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      HS_LIVE: begin
        if (deep_entry) begin
          if (ret_bit && is_freezable(mode)) begin
            st_d   = HS_HOLD;
            cap_en = 1'b1;
          end else begin
            st_d = HS_PARK;
          end
        end
      end
      HS_HOLD: begin
        if (batt_entry) begin
          st_d = HS_PARK;
        end else if (clr_pulse) begin
          st_d = HS_LIVE;
        end
      end
      HS_PARK: begin
        if (exit_ev) begin
          st_d = HS_LIVE;
        end
      end
      default: st_d = HS_LIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_LIVE;
      mode_q <= PM_ACTIVE;
    end else begin
      st_q   <= st_d;
      mode_q <= mode;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/pad_hold_bank.sv
module pad_hold_bank
  import pad_hold_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [PINS-1:0] in_oe,
  input  logic [PINS-1:0] in_out,
  input  logic [PINS-1:0] in_pull,
  output logic [PINS-1:0] hold_oe,
  output logic [PINS-1:0] hold_out,
  output logic [PINS-1:0] hold_pull
);

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pad_cfg_t cfg_d;
    pad_cfg_t cfg_q;

    assign cfg_d = '{oe: in_oe[p], out: in_out[p], pull: in_pull[p]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cap_en) begin
        cfg_q <= cfg_d;
      end
    end

    assign hold_oe[p]   = cfg_q.oe;
    assign hold_out[p]  = cfg_q.out;
    assign hold_pull[p] = cfg_q.pull;
  end

endmodule

// File: rtl/pad_hold_ctrl.sv
module pad_hold_ctrl
  import pad_hold_pkg::*;
#(
  parameter int PINS     = 8,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int RET_BIT  = 2,
  parameter int CTRL_OFS = 0,
  parameter int SYNC_LEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_rst,
  input  logic            wake,
  input  logic [2:0]      pwr_mode,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [PINS-1:0] port_oe,
  input  logic [PINS-1:0] port_out,
  input  logic [PINS-1:0] port_pull,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_pull
);

  localparam int SL = (SYNC_LEN < 1) ? 1 : SYNC_LEN;

  // asynchronous assert, synchronous release
  logic [SL-1:0] rst_sync_q;
  logic          rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SL-2:0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync_q[SL-1];

  logic            ret_bit;
  logic            clr_pulse;
  hold_st_e        hold_st;
  logic            cap_en;
  logic [PINS-1:0] hold_oe;
  logic [PINS-1:0] hold_out;
  logic [PINS-1:0] hold_pull;

  pad_hold_regs #(
    .AW      (AW),
    .DW      (DW),
    .RET_BIT (RET_BIT),
    .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ret_bit  (ret_bit),
    .clr_pulse(clr_pulse)
  );

  pad_hold_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .mode     (pwr_mode),
    .ret_bit  (ret_bit),
    .clr_pulse(clr_pulse),
    .wake     (wake),
    .sys_rst  (sys_rst),
    .state    (hold_st),
    .cap_en   (cap_en)
  );

  pad_hold_bank #(
    .PINS(PINS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cap_en   (cap_en),
    .in_oe    (port_oe),
    .in_out   (port_out),
    .in_pull  (port_pull),
    .hold_oe  (hold_oe),
    .hold_out (hold_out),
    .hold_pull(hold_pull)
  );

  // pad selection: reset config, live port, or frozen copy
  always_comb begin
    pad_oe   = '0;
    pad_out  = '0;
    pad_pull = '0;
    if (rst_q_n) begin
      unique case (hold_st)
        HS_LIVE: begin
          if (!sys_rst) begin
            pad_oe   = port_oe;
            pad_out  = port_out;
            pad_pull = port_pull;
          end
        end
        HS_HOLD: begin
          pad_oe   = hold_oe;
          pad_out  = hold_out;
          pad_pull = hold_pull;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pad_hold_chk.sv
module pad_hold_chk
  import pad_hold_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int RET_BIT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      mode,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rdata,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_pull,
  input logic            ret_bit,
  input hold_st_e        st
);

  localparam logic [DW-1:0] BIT_MASK = DW'(1) << RET_BIT;

  // R1
  por_release_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (ret_bit == 1'b0) && (st == HS_LIVE));

  // R2
  rdata_other_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != '0) |-> (rdata == '0));

  // R2
  rdata_spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> ((rdata & ~BIT_MASK) == '0));

  // R3
  bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == '0)) |=> $stable(ret_bit));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_HOLD) && ($past(st) == HS_HOLD) |->
      $stable(pad_oe) && $stable(pad_out) && $stable(pad_pull));

  // R8
  park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_PARK) |-> (pad_oe == '0) && (pad_out == '0) && (pad_pull == '0));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_HOLD) && wr_en && (addr == '0) && (rdata[RET_BIT] == 1'b1) &&
    (mode == PM_ACTIVE) |=> (st == HS_LIVE) || (ret_bit == 1'b1));

  // R9
  battery_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_BATTERY) && ($past(mode) == PM_BATTERY) |-> (st != HS_HOLD));

  // R10
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != HS_HOLD) && !is_freezable(mode) |=> (st != HS_HOLD));

endmodule

bind pad_hold_ctrl pad_hold_chk #(
  .PINS   (PINS),
  .AW     (AW),
  .DW     (DW),
  .RET_BIT(RET_BIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .mode    (pwr_mode),
  .wr_en   (reg_wr),
  .addr    (reg_addr),
  .rdata   (reg_rdata),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .pad_pull(pad_pull),
  .ret_bit (ret_bit),
  .st      (hold_st)
);

// File: tb/test_pad_hold_ctrl.sv
module test_pad_hold_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PINS       = 8;
  localparam int AW         = 8;
  localparam int DW         = 8;
  localparam int WD_CYCLES  = 100000;

  logic            clk;
  logic            rst_n;
  logic            sys_rst;
  logic            wake;
  logic [2:0]      pwr_mode;
  logic            reg_wr;
  logic [AW-1:0]   reg_addr;
  logic [DW-1:0]   reg_wdata;
  logic [DW-1:0]   reg_rdata;
  logic [PINS-1:0] port_oe, port_out, port_pull;
  logic [PINS-1:0] pad_oe, pad_out, pad_pull;

  int n_chk;
  int n_bad;
  bit finished;

  pad_hold_ctrl #(.PINS(PINS), .AW(AW), .DW(DW)) i_pad_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wake(wake),
    .pwr_mode(pwr_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_oe(port_oe), .port_out(port_out), .port_pull(port_pull),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // reference model state
  bit              m_bit;
  int              m_st;   // 0 live, 1 frozen, 2 parked
  logic [PINS-1:0] m_oe, m_out, m_pull;
  logic [2:0]      m_mq;

  function automatic bit deep(input logic [2:0] m);
    return (m == 3'd3) || (m == 3'd4) || (m == 3'd6);
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    return (reg_addr == '0) ? DW'({m_bit, 2'b00}) : '0;
  endfunction

  function automatic logic [3*PINS-1:0] exp_pads();
    if (m_st == 0) return sys_rst ? '0 : {port_oe, port_out, port_pull};
    if (m_st == 1) return {m_oe, m_out, m_pull};
    return '0;
  endfunction

  task automatic compare(input string tag, input logic [3*PINS-1:0] ep,
                         input logic [DW-1:0] er);
    n_chk++;
    if ({pad_oe, pad_out, pad_pull} !== ep || reg_rdata !== er) begin
      n_bad++;
      $display("FAIL %s t=%0t: pads=%h rdata=%h expected pads=%h rdata=%h",
               tag, $time, {pad_oe, pad_out, pad_pull}, reg_rdata, ep, er);
    end
  endtask

  // inputs already set; check, advance model, step one edge
  task automatic cyc(input string tag);
    bit entry, bentry, clr;
    #1;
    compare(tag, exp_pads(), exp_rdata());
    entry  = deep(pwr_mode) && !deep(m_mq);
    bentry = (pwr_mode == 3'd6) && (m_mq != 3'd6);
    clr    = reg_wr && (reg_addr == '0) && !reg_wdata[2];
    case (m_st)
      0: if (entry) begin
        if (m_bit && (pwr_mode == 3'd3 || pwr_mode == 3'd4)) begin
          m_st = 1; m_oe = port_oe; m_out = port_out; m_pull = port_pull;
        end else m_st = 2;
      end
      1: if (bentry) m_st = 2; else if (clr) m_st = 0;
      default: if (wake || sys_rst) m_st = 0;
    endcase
    if (reg_wr && reg_addr == '0) m_bit = reg_wdata[2];
    m_mq = pwr_mode;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    reg_wr = 0; reg_addr = '0; reg_wdata = '0; sys_rst = 0; wake = 0;
  endtask

  task automatic new_port();
    port_oe = PINS'($urandom); port_out = PINS'($urandom);
    port_pull = PINS'($urandom);
  endtask

  task automatic wr_bit(input bit v, input string tag);
    reg_wr = 1; reg_addr = '0; reg_wdata = v ? 8'h04 : 8'h00;
    cyc(tag);
    quiet();
  endtask

  task automatic go_mode(input logic [2:0] m, input string tag);
    pwr_mode = m; new_port(); cyc(tag);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R4: run did not end, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    n_chk = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0;
    pwr_mode = 3'd0; quiet();
    port_oe = '1; port_out = '1; port_pull = '1;
    // R1: pads at reset config while power-on reset is held
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if ({pad_oe, pad_out, pad_pull} !== '0 || reg_rdata !== '0) begin
      n_bad++;
      $display("FAIL R1: pads=%h rdata=%h expected 0/0",
               {pad_oe, pad_out, pad_pull}, reg_rdata);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_bit = 0; m_st = 0; m_oe = '0; m_out = '0; m_pull = '0; m_mq = 3'd0;
    new_port(); cyc("R1");
    new_port(); cyc("R4");

    // R2: register field position and decode
    reg_wr = 1; reg_addr = '0; reg_wdata = 8'hFF; cyc("R2");
    reg_wr = 1; reg_addr = 8'h01; reg_wdata = 8'h00; cyc("R2");
    quiet(); reg_addr = 8'h01; cyc("R2");
    quiet(); cyc("R2");
    wr_bit(0, "R2");

    // R5 freeze on hibernate entry, R6 persistence
    wr_bit(1, "R5");
    go_mode(3'd0, "R5");
    go_mode(3'd3, "R5");
    go_mode(3'd3, "R5");
    go_mode(3'd0, "R6");
    sys_rst = 1; new_port(); cyc("R6"); sys_rst = 0;
    wake = 1; new_port(); cyc("R6"); wake = 0;
    go_mode(3'd1, "R6");
    go_mode(3'd5, "R6");
    go_mode(3'd0, "R3");
    // R7 release
    wr_bit(0, "R7");
    go_mode(3'd0, "R7");
    go_mode(3'd0, "R7");

    // R8 park with bit clear on backup entry
    go_mode(3'd4, "R8");
    go_mode(3'd4, "R8");
    go_mode(3'd0, "R8");
    wake = 1; new_port(); cyc("R8"); wake = 0;
    go_mode(3'd0, "R8");
    go_mode(3'd3, "R8");
    sys_rst = 1; new_port(); cyc("R8"); sys_rst = 0;
    go_mode(3'd0, "R8");

    // R9 battery mode ignores the bit and drops a freeze
    wr_bit(1, "R9");
    go_mode(3'd6, "R9");
    go_mode(3'd6, "R9");
    wake = 1; new_port(); cyc("R9"); wake = 0;
    go_mode(3'd0, "R9");
    go_mode(3'd4, "R9");
    go_mode(3'd6, "R9");
    go_mode(3'd6, "R9");
    sys_rst = 1; new_port(); cyc("R3"); sys_rst = 0;
    go_mode(3'd0, "R9");

    // R10 shallow modes never freeze
    go_mode(3'd1, "R10");
    go_mode(3'd2, "R10");
    go_mode(3'd5, "R10");
    go_mode(3'd7, "R10");
    go_mode(3'd0, "R10");
    wr_bit(0, "R10");

    // R4 live pass-through and warm reset under random traffic
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0) pwr_mode = 3'($urandom % 8);
      reg_wr    = (($urandom % 12) == 0);
      reg_addr  = (($urandom % 4) == 0) ? AW'($urandom) : '0;
      reg_wdata = DW'($urandom);
      sys_rst   = (($urandom % 24) == 0);
      wake      = (($urandom % 24) == 0);
      new_port();
      cyc("R4");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule